// File: doc/BRIEF.md
# GPIO pin interrupt and wake detector

This block is the control and status word of one general-purpose pin, together with the logic that turns activity on that pin into interrupt and wake requests. A single 32-bit word sets the pad direction and output level. It also selects how the already-debounced input is watched: for a rising, falling or either edge, or for a held high or low level. Separate bits let the pin raise an interrupt and let it wake the system, with one wake enable for each of three low-power states.

An interrupt status bit and a wake status bit record detected events. Software clears each one by writing 1 to its position, so writing back a word just read clears whatever that read showed as pending. A common mask bit decides whether a recorded status is forwarded on the pending lines that feed a summary block. In level mode the status is set again on every cycle while the active level persists, so clearing it has no lasting effect until the input goes inactive.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset every configuration bit and both status bits are 0, `pad_oe`, `pad_out`, `int_pend` and `wake_pend` are low, and `rd_data` reads 0 apart from the live pin level in bit 16.
- R2: Bits 13:0 are read/write and read back as last written: 0 pad output enable, 1 pad output value, 2 trigger type (0 edge, 1 level), 4:3 active selection, 5 interrupt enable, 6 unmask, 9:7 wake enables, 11:10 pull setting and 13:12 drive setting (the last two stored only). Bits 15:14 and 31:19 read 0, and writes to bit 16 are ignored.
- R3: Bit 16 of `rd_data` always equals `pin_lvl` in the same cycle.
- R4: With bit 0 set, `pad_oe` is 1 and `pad_out` follows bit 1. With bit 0 clear, both `pad_oe` and `pad_out` are 0.
- R5: In edge mode the active selection codes are 00 rising, 01 falling, 10 either edge and 11 none. An edge is the input value differing from the value held at the previous clock edge. A selected edge sets the interrupt status (bit 17) at the clock edge where the new level is first sampled.
- R6: In level mode, code 00 detects a high input and 01 a low input, and codes 10 and 11 detect nothing. The interrupt status is set on every clock edge while the active level is present, so it stays 1 even across a clear.
- R7: With bit 5 clear, a detected event does not set the interrupt status, and a status that is already set keeps its value.
- R8: Writing 1 to bit 17 clears the interrupt status and writing 1 to bit 18 clears the wake status. Writing 0 to either bit leaves it unchanged. A detection in the same cycle as a clear wins, and the status is set.
- R9: `int_pend` is the interrupt status AND bit 6, and `wake_pend` is the wake status AND bit 6.
- R10: A detected event sets the wake status (bit 18) when `pwr_state` is 1, 2 or 3 and the matching wake enable (bit 7, 8 or 9) is set. With `pwr_state` 0 it never sets. The wake status does not depend on bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | 1 | Debounced pin level |
| pwr_state | input | 2 | Power state: 0 running, 1 idle, 2 sleep, 3 off |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Current control and status word |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| int_pend | output | 1 | Unmasked interrupt pending |
| wake_pend | output | 1 | Unmasked wake pending |

## Verification
The pin-level bit is combinational, so it is checked one time step after the input changes and before the next clock edge. A write reaches the configuration bits and pad outputs at the next rising edge. An input change is recorded in the status bits and the pending lines at the rising edge where it is first sampled. The bench therefore changes inputs on the falling edge and reads every registered result at the following falling edge, exactly one rising edge later. The trigger sweep first primes the previous input level and clears the status under the new configuration, so each expected value depends only on the chosen previous and current levels.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    // Bit positions in the control and status word
    localparam int B_OE       = 0;
    localparam int B_OV       = 1;
    localparam int B_TRIG     = 2;
    localparam int B_SEL_LO   = 3;
    localparam int B_SEL_HI   = 4;
    localparam int B_INT_EN   = 5;
    localparam int B_UNMASK   = 6;
    localparam int B_WK_LO    = 7;
    localparam int B_WK_HI    = 9;
    localparam int CFG_W      = 14;
    localparam int B_PIN      = 16;
    localparam int B_INT_STS  = 17;
    localparam int B_WAKE_STS = 18;
    localparam int WORD_MIN   = B_WAKE_STS + 1;

    typedef enum logic [1:0] {
        SEL_HI_RISE = 2'b00,
        SEL_LO_FALL = 2'b01,
        SEL_BOTH    = 2'b10,
        SEL_NONE    = 2'b11
    } act_sel_e;

    // Packed MSB first so that bit 0 is the output enable
    typedef struct packed {
        logic [1:0] drive;
        logic [1:0] pull;
        logic [2:0] wake_en;
        logic       unmask;
        logic       int_en;
        act_sel_e   sel;
        logic       level_mode;
        logic       out_val;
        logic       out_en;
    } pin_cfg_t;

    typedef struct packed {
        logic int_sts;
        logic wake_sts;
    } pin_sts_t;

endpackage

// File: rtl/pin_cfg_reg.sv
module pin_cfg_reg
    import gpio_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  pin_cfg_t wr_cfg,
    output pin_cfg_t cfg_q
);

    pin_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/pin_event_det.sv
module pin_event_det
    import gpio_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_lvl,
    input  logic     level_mode,
    input  act_sel_e sel,
    output logic     hit
);

    logic pin_d, pin_q;
    logic rise, fall;

    always_comb begin
        pin_d = pin_lvl;
        rise  = pin_lvl & ~pin_q;
        fall  = ~pin_lvl & pin_q;
        hit   = 1'b0;
        if (level_mode) begin
            unique case (sel)
                SEL_HI_RISE: hit = pin_lvl;
                SEL_LO_FALL: hit = ~pin_lvl;
                default:     hit = 1'b0;
            endcase
        end else begin
            unique case (sel)
                SEL_HI_RISE: hit = rise;
                SEL_LO_FALL: hit = fall;
                SEL_BOTH:    hit = rise | fall;
                default:     hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

endmodule

// File: rtl/pin_sts_reg.sv
module pin_sts_reg
    import gpio_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic int_en,
    input  logic wake_arm,
    input  logic clr_int,
    input  logic clr_wake,
    input  logic unmask,
    output logic int_sts,
    output logic wake_sts,
    output logic int_pend,
    output logic wake_pend
);

    pin_sts_t sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        // Clear first, then a detection in the same cycle overrides it
        if (clr_int) begin
            sts_d.int_sts = 1'b0;
        end
        if (clr_wake) begin
            sts_d.wake_sts = 1'b0;
        end
        if (hit && int_en) begin
            sts_d.int_sts = 1'b1;
        end
        if (hit && wake_arm) begin
            sts_d.wake_sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign int_sts   = sts_q.int_sts;
    assign wake_sts  = sts_q.wake_sts;
    assign int_pend  = sts_q.int_sts & unmask;
    assign wake_pend = sts_q.wake_sts & unmask;

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_pin_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_lvl,
    input  logic [1:0]       pwr_state,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pad_oe,
    output logic             pad_out,
    output logic             int_pend,
    output logic             wake_pend
);

    localparam int UPPER_W = REG_W - WORD_MIN;

    pin_cfg_t cfg_q;
    logic     hit;
    logic     wake_arm;
    logic     int_sts, wake_sts;
    logic     unused_wr;

    pin_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cfg (pin_cfg_t'(wr_data[CFG_W-1:0])),
        .cfg_q  (cfg_q)
    );

    pin_event_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .level_mode (cfg_q.level_mode),
        .sel        (cfg_q.sel),
        .hit        (hit)
    );

    // Pick the wake enable that belongs to the present power state
    always_comb begin
        unique case (pwr_state)
            2'd1:    wake_arm = cfg_q.wake_en[0];
            2'd2:    wake_arm = cfg_q.wake_en[1];
            2'd3:    wake_arm = cfg_q.wake_en[2];
            default: wake_arm = 1'b0;
        endcase
    end

    pin_sts_reg u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .int_en    (cfg_q.int_en),
        .wake_arm  (wake_arm),
        .clr_int   (wr_en & wr_data[B_INT_STS]),
        .clr_wake  (wr_en & wr_data[B_WAKE_STS]),
        .unmask    (cfg_q.unmask),
        .int_sts   (int_sts),
        .wake_sts  (wake_sts),
        .int_pend  (int_pend),
        .wake_pend (wake_pend)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[CFG_W-1:0]     = cfg_q;
        rd_data[B_PIN]         = pin_lvl;
        rd_data[B_INT_STS]     = int_sts;
        rd_data[B_WAKE_STS]    = wake_sts;
    end

    assign pad_oe  = cfg_q.out_en;
    assign pad_out = cfg_q.out_en & cfg_q.out_val;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign unused_wr = ^{wr_data[REG_W-1:WORD_MIN], wr_data[B_PIN:CFG_W]};
        end else begin : g_exact
            assign unused_wr = ^wr_data[B_PIN:CFG_W];
        end
    endgenerate

endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk
    import gpio_pin_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_lvl,
    input logic [1:0]       pwr_state,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             pad_oe,
    input logic             pad_out,
    input logic             int_pend,
    input logic             wake_pend
);

    logic clr_int_req;
    assign clr_int_req = wr_en & wr_data[B_INT_STS];

    AST_PAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> !pad_out); // R4

    AST_INT_PEND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend |-> (rd_data[B_INT_STS] && rd_data[B_UNMASK])); // R9

    AST_WAKE_PEND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pend |-> (rd_data[B_WAKE_STS] && rd_data[B_UNMASK])); // R9

    AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_INT_EN] && !rd_data[B_INT_STS]) |=> !rd_data[B_INT_STS]); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int_req && !rd_data[B_INT_EN]) |=> !rd_data[B_INT_STS]); // R8

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_TRIG] && rd_data[B_INT_EN] &&
         rd_data[B_SEL_HI:B_SEL_LO] == 2'b00 && pin_lvl) |=> rd_data[B_INT_STS]); // R6

    AST_NO_WAKE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !rd_data[B_WAKE_STS]) |=> !rd_data[B_WAKE_STS]); // R10

endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .pwr_state (pwr_state),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .int_pend  (int_pend),
    .wake_pend (wake_pend)
);

// File: tb/gpio_pin_irq_bench.sv
module gpio_pin_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_lvl = 1'b0;
    logic [1:0]       pwr_state = 2'd0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             pad_oe, pad_out, int_pend, wake_pend;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_irq #(.REG_W(REG_W)) u_gpio_pin_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .pwr_state (pwr_state),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .int_pend  (int_pend),
        .wake_pend (wake_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic lvl_hit(input int sel, input logic v);
        if (sel == 0) return v;
        if (sel == 1) return ~v;
        return 1'b0;
    endfunction

    function automatic logic edge_hit(input int sel, input logic p, input logic c);
        if (sel == 0) return ~p & c;
        if (sel == 1) return p & ~c;
        if (sel == 2) return p ^ c;
        return 1'b0;
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] cfg;
        logic        exp;

        // R1: reset state, pin held high during reset
        pin_lvl = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rd in reset", rd_data, 32'h0001_0000);
        chk("R1 outputs in reset", {28'd0, pad_oe, pad_out, int_pend, wake_pend}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rd after reset", rd_data, 32'h0001_0000);
        chk("R1 outputs after reset", {28'd0, pad_oe, pad_out, int_pend, wake_pend}, 32'd0);

        // R3: pin mirror, same cycle
        for (int v = 0; v < 4; v++) begin
            pin_lvl = v[0];
            #1;
            chk("R3 pin bit", {31'd0, rd_data[16]}, {31'd0, v[0]});
            @(negedge clk);
        end

        // R2: all ones written, only storage bits read back
        @(negedge clk);
        pin_lvl = 1'b0;
        wr_en   = 1'b1;
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 readback all ones", rd_data, 32'h0000_3FFF);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 32'h0001_2A5C;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 readback pattern", rd_data, 32'h0000_2A5C);

        // R4: pad direction and value
        for (int m = 0; m < 4; m++) begin
            wr_en   = 1'b1;
            wr_data = 32'(m);
            @(negedge clk);
            wr_en = 1'b0;
            chk("R4 pad_oe", {31'd0, pad_oe}, {31'd0, m[0]});
            chk("R4 pad_out", {31'd0, pad_out}, {31'd0, m[0] & m[1]});
        end

        // R5 / R6 / R8: trigger sweep over mode, selection, previous and current level
        for (int lm = 0; lm < 2; lm++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int c = 0; c < 2; c++) begin
                        cfg = 32'(lm << 2) | 32'(sel << 3) | 32'h60;
                        wr_en   = 1'b1;
                        wr_data = cfg;
                        pin_lvl = p[0];
                        @(negedge clk);
                        wr_data = cfg | 32'h0002_0000;
                        @(negedge clk);
                        wr_en   = 1'b0;
                        pin_lvl = c[0];
                        @(negedge clk);
                        if (lm == 0) begin
                            exp = edge_hit(sel, p[0], c[0]);
                            chk("R5 edge status", {31'd0, rd_data[17]}, {31'd0, exp});
                        end else begin
                            exp = lvl_hit(sel, p[0]) | lvl_hit(sel, c[0]);
                            chk("R6 R8 level status", {31'd0, rd_data[17]}, {31'd0, exp});
                        end
                        chk("R9 int_pend unmasked", {31'd0, int_pend}, {31'd0, exp});
                    end
                end
            end
        end

        // R9: masked status does not pend, then unmask
        wr_en   = 1'b1;
        wr_data = 32'h0002_0024;        // level, high, int enable, masked, clear
        pin_lvl = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R9 masked status set", {31'd0, rd_data[17]}, 32'd1);
        chk("R9 masked no pend", {31'd0, int_pend}, 32'd0);
        wr_en   = 1'b1;
        wr_data = 32'h0000_0040;        // int disabled, unmasked, edge
        pin_lvl = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 unmask pends", {31'd0, int_pend}, 32'd1);
        // R7: disabled, status held; R8 writing 0 leaves it
        pin_lvl = 1'b1;
        @(negedge clk);
        chk("R7 R8 status kept", {31'd0, rd_data[17]}, 32'd1);
        wr_en   = 1'b1;
        wr_data = 32'h0002_0040;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 clear", {31'd0, rd_data[17]}, 32'd0);
        pin_lvl = 1'b0;
        @(negedge clk);
        pin_lvl = 1'b1;
        @(negedge clk);
        chk("R7 disabled no latch", {31'd0, rd_data[17]}, 32'd0);

        // R10 / R7: wake sweep over power state and wake enables
        for (int ps = 0; ps < 4; ps++) begin
            for (int wm = 0; wm < 8; wm++) begin
                cfg = 32'h40 | 32'(wm << 7);
                pwr_state = 2'(ps);
                wr_en   = 1'b1;
                wr_data = cfg | 32'h0006_0000;
                pin_lvl = 1'b0;
                @(negedge clk);
                @(negedge clk);
                wr_en   = 1'b0;
                pin_lvl = 1'b1;
                @(negedge clk);
                exp = (ps != 0) && wm[ps-1 < 0 ? 0 : ps-1];
                chk("R10 wake status", {31'd0, rd_data[18]}, {31'd0, exp});
                chk("R10 R9 wake_pend", {31'd0, wake_pend}, {31'd0, exp});
                chk("R7 int untouched", {31'd0, rd_data[17]}, 32'd0);
            end
        end

        // R8: writing 1 to the wake status clears it
        wr_en   = 1'b1;
        wr_data = 32'h0004_0040;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 wake clear", {31'd0, rd_data[18]}, 32'd0);

        summary();
        $finish;
    end

endmodule